// File: doc/BRIEF.md
# Sleep, Wake and Power-Down Mode Controller

This block holds the operating mode of a peripheral device: an initialisation window after reset, then operating, sleeping, serving a host access that arrived during sleep, or powered down. It watches a level-sensitive wake pin, an active-low power-down pin, the SPI chip select and a one-cycle "host request served" pulse from the transport logic. From these it drives a status pin, an enable for the device's functional clocks and a request to the power logic to enter its low-power state.

Every pin input passes through a two-flop synchroniser. The wake and power-down levels are also debounced, so a change must hold for a set number of clocks before the mode follows it. The chip select is not debounced: its falling and rising edges are taken from the synchronised level, so a short host access is still seen. At the end of the initialisation window the block latches a transport-select strap, which then stays fixed until the next reset. Power-down is final: clocks stop, and only the asynchronous reset brings the block back.

Top module: `mode_ctl`

## Requirements
- R1: After reset the block spends INIT_CYCLES clocks, counted from the synchronised release of reset, in an initialisation window with status_o=0, clk_en_o=1 and sleep_req_o=0. It then enters the operating or sleep mode according to the settled wake level. INIT_CYCLES must exceed SYNC_STAGES+DEBOUNCE_CYCLES.
- R2: When the debounced wake level is low in the operating mode, the block enters sleep, with status_o=0, clk_en_o=0 and sleep_req_o=1.
- R3: When the debounced wake level is high in sleep, the block enters the operating mode, with status_o=1, clk_en_o=1 and sleep_req_o=0.
- R4: The wake and power-down pins are synchronised and then debounced. A level that holds for fewer than DEBOUNCE_CYCLES clocks has no effect. A level that holds acts within SYNC_STAGES+DEBOUNCE_CYCLES+2 clocks.
- R5: A falling edge of the synchronised chip select during sleep enters a host-serve mode, with status_o=1, clk_en_o=1 and sleep_req_o=0.
- R6: In the host-serve mode a low wake level is ignored until served_i pulses or the chip select rises.
- R7: On leaving the host-serve mode, the block goes to the operating mode if the debounced wake level is high and to sleep if it is low.
- R8: A debounced low power-down level enters power-down from any mode, with status_o=0, clk_en_o=0 and sleep_req_o=0. Power-down takes precedence over every other transition, and reset takes precedence over power-down.
- R9: Power-down is left only through rst_n. Raising the power-down pin, raising the wake pin or toggling the chip select has no effect on it.
- R10: xport_spi_o takes the synchronised strap value in the last cycle of the initialisation window (1 selects SPI, 0 selects UART). It stays 0 during the window, and later changes of strap_i do not affect it.
- R11: A chip-select falling edge in the operating mode does not change the mode; a later low wake level still puts the block to sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_pin_i | input | 1 | Wake level from the pin: high runs, low sleeps (asynchronous) |
| pdn_n_i | input | 1 | Active-low power-down pin (asynchronous) |
| cs_n_i | input | 1 | SPI chip select, active low (asynchronous) |
| strap_i | input | 1 | Transport-select strap: 1 SPI, 0 UART (asynchronous) |
| served_i | input | 1 | One-cycle pulse, synchronous to clk: the host access is complete |
| status_o | output | 1 | Status pin: 1 while operating or serving the host |
| clk_en_o | output | 1 | Enable for the device's functional clocks |
| sleep_req_o | output | 1 | Request to the power logic to enter sleep |
| xport_spi_o | output | 1 | Latched transport selection |

## Verification
The bench builds the block with DEBOUNCE_CYCLES=4, INIT_CYCLES=8 and the default two synchroniser stages. With these values the initialisation window, the debounce filter and the latency of every pin fit inside a few tens of clocks. This lets a single run cover a two-clock glitch that must be rejected, every path through the host-serve mode, power-down entered from sleep and from host-serve, and a reset with each strap value.

// File: rtl/mode_ctl_pkg.sv
package mode_ctl_pkg;
  typedef enum logic [2:0] {
    MD_INIT  = 3'd0,
    MD_RUN   = 3'd1,
    MD_SLEEP = 3'd2,
    MD_HOST  = 3'd3,
    MD_PDN   = 3'd4
  } mode_e;
endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/pmc_debounce.sv
module pmc_debounce #(
  parameter int           W       = 1,
  parameter int           CYCLES  = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int CW = $clog2(CYCLES + 1);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [CW-1:0] cnt_q;
    logic          lvl_q;
    logic          differs;
    logic          expire;

    assign differs = (din[b] != lvl_q);
    assign expire  = (cnt_q == CW'(CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        lvl_q <= RST_VAL[b];
      end else if (!differs) begin
        cnt_q <= '0;
      end else if (expire) begin
        cnt_q <= '0;
        lvl_q <= din[b];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    assign dout[b] = lvl_q;
  end
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import mode_ctl_pkg::*;
#(
  parameter int INIT_CYCLES = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wake_d,
  input  logic  pdn_n_d,
  input  logic  cs_n_s,
  input  logic  strap_s,
  input  logic  served,
  output mode_e mode,
  output logic  cs_fall,
  output logic  cs_rise,
  output logic  xport_spi
);
  localparam int IW = $clog2(INIT_CYCLES + 1);

  mode_e         mode_q, mode_d;
  logic [IW-1:0] init_cnt_q;
  logic          init_last;
  logic          cs_n_prev_q;
  logic          spi_q;

  assign init_last = (mode_q == MD_INIT) && (init_cnt_q == IW'(INIT_CYCLES - 1));
  assign cs_fall   = cs_n_prev_q & ~cs_n_s;
  assign cs_rise   = ~cs_n_prev_q & cs_n_s;

  always_comb begin
    mode_d = mode_q;
    if (mode_q != MD_PDN && !pdn_n_d) begin
      mode_d = MD_PDN;
    end else begin
      case (mode_q)
        MD_INIT:  if (init_last) mode_d = wake_d ? MD_RUN : MD_SLEEP;
        MD_RUN:   if (!wake_d) mode_d = MD_SLEEP;
        MD_SLEEP: begin
          if (wake_d)       mode_d = MD_RUN;
          else if (cs_fall) mode_d = MD_HOST;
        end
        MD_HOST:  if (served || cs_rise) mode_d = wake_d ? MD_RUN : MD_SLEEP;
        MD_PDN:   mode_d = MD_PDN;
        default:  mode_d = MD_PDN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MD_INIT;
    else        mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 init_cnt_q <= '0;
    else if (mode_q == MD_INIT && !init_last) init_cnt_q <= init_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_n_prev_q <= 1'b1;
    else        cs_n_prev_q <= cs_n_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         spi_q <= 1'b0;
    else if (init_last) spi_q <= strap_s;
  end

  assign mode      = mode_q;
  assign xport_spi = spi_q;
endmodule

// File: rtl/mode_ctl.sv
module mode_ctl
  import mode_ctl_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 16,
  parameter int INIT_CYCLES     = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_pin_i,
  input  logic pdn_n_i,
  input  logic cs_n_i,
  input  logic strap_i,
  input  logic served_i,
  output logic status_o,
  output logic clk_en_o,
  output logic sleep_req_o,
  output logic xport_spi_o
);
  localparam int           NPIN     = 4;
  localparam logic [NPIN-1:0] PIN_RST = 4'b0110;
  localparam int           NDEB     = 2;
  localparam logic [NDEB-1:0] DEB_RST = 2'b10;

  logic            srst_n;
  logic [NPIN-1:0] pins_s;
  logic [NDEB-1:0] lvl_d;
  logic            wake_d, pdn_n_d, cs_n_s, strap_s;
  logic            cs_fall, cs_rise;
  mode_e           mode;

  pmc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  pmc_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(srst_n),
    .din({strap_i, cs_n_i, pdn_n_i, wake_pin_i}),
    .dout(pins_s)
  );

  assign strap_s = pins_s[3];
  assign cs_n_s  = pins_s[2];

  pmc_debounce #(.W(NDEB), .CYCLES(DEBOUNCE_CYCLES), .RST_VAL(DEB_RST)) u_deb (
    .clk(clk), .rst_n(srst_n), .din(pins_s[1:0]), .dout(lvl_d)
  );

  assign pdn_n_d = lvl_d[1];
  assign wake_d  = lvl_d[0];

  pmc_fsm #(.INIT_CYCLES(INIT_CYCLES)) u_fsm (
    .clk(clk), .rst_n(srst_n),
    .wake_d(wake_d), .pdn_n_d(pdn_n_d), .cs_n_s(cs_n_s), .strap_s(strap_s),
    .served(served_i),
    .mode(mode), .cs_fall(cs_fall), .cs_rise(cs_rise), .xport_spi(xport_spi_o)
  );

  assign status_o    = (mode == MD_RUN) || (mode == MD_HOST);
  assign clk_en_o    = (mode == MD_INIT) || (mode == MD_RUN) || (mode == MD_HOST);
  assign sleep_req_o = (mode == MD_SLEEP);
endmodule

// File: rtl/mode_ctl_checker.sv
module mode_ctl_checker
  import mode_ctl_pkg::*;
(
  input logic  clk,
  input logic  srst_n,
  input logic  status_o,
  input logic  clk_en_o,
  input logic  sleep_req_o,
  input logic  xport_spi_o,
  input mode_e mode,
  input logic  wake_d,
  input logic  pdn_n_d,
  input logic  cs_fall,
  input logic  cs_rise,
  input logic  served_i
);
  a_r8_pdn_entry: assert property (@(posedge clk) disable iff (!srst_n)
    !pdn_n_d |=> (!status_o && !clk_en_o && !sleep_req_o));

  a_r9_pdn_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == MD_PDN) |=> (mode == MD_PDN));

  a_r2_run_to_sleep: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == MD_RUN && !wake_d && pdn_n_d) |=> sleep_req_o);

  a_r3_sleep_to_run: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == MD_SLEEP && wake_d && pdn_n_d) |=> (status_o && clk_en_o));

  a_r5_cs_wakes: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == MD_SLEEP && cs_fall && pdn_n_d) |=> (status_o && clk_en_o && !sleep_req_o));

  a_r6_host_holds: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == MD_HOST && !served_i && !cs_rise && pdn_n_d) |=> (mode == MD_HOST));

  a_r10_strap_fixed: assert property (@(posedge clk) disable iff (!srst_n)
    (mode != MD_INIT && $past(mode) != MD_INIT) |-> $stable(xport_spi_o));
endmodule

bind mode_ctl mode_ctl_checker u_mode_ctl_chk (
  .clk(clk), .srst_n(srst_n),
  .status_o(status_o), .clk_en_o(clk_en_o), .sleep_req_o(sleep_req_o),
  .xport_spi_o(xport_spi_o), .mode(mode),
  .wake_d(wake_d), .pdn_n_d(pdn_n_d), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .served_i(served_i)
);

// File: tb/mode_ctl_bench.sv
`timescale 1ns/1ps
module mode_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake = 1'b0, pdn_n = 1'b1, cs_n = 1'b1, strap = 1'b0, served = 1'b0;
  logic status, clk_en, sleep_req, xport_spi;
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;

  always #2.5 clk = ~clk;

  mode_ctl #(.SYNC_STAGES(2), .DEBOUNCE_CYCLES(4), .INIT_CYCLES(8)) u_mode_ctl (
    .clk(clk), .rst_n(rst_n), .wake_pin_i(wake), .pdn_n_i(pdn_n), .cs_n_i(cs_n),
    .strap_i(strap), .served_i(served),
    .status_o(status), .clk_en_o(clk_en), .sleep_req_o(sleep_req),
    .xport_spi_o(xport_spi)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // status, clock enable, sleep request
  task automatic check_mode(input string tag, input logic st, input logic ce, input logic sr);
    checks++;
    if ({status, clk_en, sleep_req} !== {st, ce, sr}) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, {status, clk_en, sleep_req}, {st, ce, sr});
    end
  endtask

  task automatic do_reset(input logic strap_v, input logic wake_v);
    @(negedge clk);
    rst_n = 1'b0;
    strap = strap_v; wake = wake_v; pdn_n = 1'b1; cs_n = 1'b1; served = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic pulse_served();
    @(negedge clk) served = 1'b1;
    @(negedge clk) served = 1'b0;
  endtask

  task automatic t_reset_init();
    do_reset(1'b1, 1'b1);
    wait_cyc(2);
    check_mode("R1 init window", 1'b0, 1'b1, 1'b0);
    check_bit("R10 strap before latch", xport_spi, 1'b0);
    wait_cyc(20);
    check_mode("R1 init to run", 1'b1, 1'b1, 1'b0);
    check_bit("R10 strap spi", xport_spi, 1'b1);
  endtask

  task automatic t_sleep_wake();
    wake = 1'b0; wait_cyc(10);
    check_mode("R2 sleep", 1'b0, 1'b0, 1'b1);
    wake = 1'b1; wait_cyc(10);
    check_mode("R3 wake", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_glitch();
    wake = 1'b0; wait_cyc(2); wake = 1'b1; wait_cyc(12);
    check_mode("R4 low glitch ignored", 1'b1, 1'b1, 1'b0);
    wake = 1'b0; wait_cyc(12);
    check_mode("R4 held low acts", 1'b0, 1'b0, 1'b1);
    wake = 1'b1; wait_cyc(2); wake = 1'b0; wait_cyc(12);
    check_mode("R4 high glitch ignored", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_host();
    cs_n = 1'b0; wait_cyc(8);
    check_mode("R5 cs wakes", 1'b1, 1'b1, 1'b0);
    wait_cyc(20);
    check_mode("R6 low wake ignored", 1'b1, 1'b1, 1'b0);
    pulse_served(); wait_cyc(3);
    check_mode("R7 served back to sleep", 1'b0, 1'b0, 1'b1);
    cs_n = 1'b1; wait_cyc(8);
    cs_n = 1'b0; wait_cyc(8);
    check_mode("R5 second cs wake", 1'b1, 1'b1, 1'b0);
    cs_n = 1'b1; wait_cyc(8);
    check_mode("R7 cs rise back to sleep", 1'b0, 1'b0, 1'b1);
    cs_n = 1'b0; wait_cyc(8);
    wake = 1'b1; wait_cyc(12);
    check_mode("R6 host with wake high", 1'b1, 1'b1, 1'b0);
    pulse_served(); cs_n = 1'b1; wait_cyc(8);
    check_mode("R7 served to run", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_run_cs();
    cs_n = 1'b0; wait_cyc(8); cs_n = 1'b1; wait_cyc(8);
    check_mode("R11 cs in run no change", 1'b1, 1'b1, 1'b0);
    wake = 1'b0; wait_cyc(10);
    check_mode("R11 sleep after run cs", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_strap();
    strap = 1'b0; wait_cyc(20);
    check_bit("R10 strap change ignored", xport_spi, 1'b1);
    do_reset(1'b0, 1'b0);
    wait_cyc(20);
    check_bit("R10 strap uart", xport_spi, 1'b0);
    check_mode("R1 init to sleep", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_pdn();
    pdn_n = 1'b0; wait_cyc(10);
    check_mode("R8 pdn from sleep", 1'b0, 1'b0, 1'b0);
    pdn_n = 1'b1; wake = 1'b1; wait_cyc(12);
    cs_n = 1'b0; wait_cyc(6); cs_n = 1'b1; wait_cyc(20);
    check_mode("R9 pdn sticky", 1'b0, 1'b0, 1'b0);
    do_reset(1'b1, 1'b1); wait_cyc(20);
    check_mode("R9 reset exits pdn", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_pdn_host();
    wake = 1'b0; wait_cyc(10);
    cs_n = 1'b0; wait_cyc(8);
    check_mode("R5 host before pdn", 1'b1, 1'b1, 1'b0);
    pdn_n = 1'b0; wait_cyc(10);
    check_mode("R8 pdn over host", 1'b0, 1'b0, 1'b0);
    pulse_served(); cs_n = 1'b1; wait_cyc(8);
    check_mode("R9 served ignored in pdn", 1'b0, 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check_mode("R8 reset over pdn", 1'b0, 1'b1, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
      end
    end
  end

  initial begin
    t_reset_init();
    t_sleep_wake();
    t_glitch();
    t_host();
    t_run_cs();
    t_strap();
    t_pdn();
    t_pdn_host();
    wait_cyc(4);
    finish_run();
  end
endmodule